// File: doc/BRIEF.md
# Table-Driven Multi-Byte Instruction Decoder

This block identifies one instruction from a window of up to five leading bytes of an instruction stream. It does this by walking a chain of lookups through one shared, software-loaded decode table. Each lookup uses the current state together with one instruction byte. A lookup returns one of three kinds of signed 16-bit word:

- a negative word asks for another byte and names the state to use for it;
- a positive word ends the decode and points into a second table of instruction identifiers;
- a zero word marks an encoding that must trap.

All five lookups are resolved combinationally in the same cycle. The result is captured in one output register.

The byte window comes in on a valid/ready channel, and the result goes out on a second valid/ready channel. The output register is the only storage between the two channels. A new window is accepted whenever the output register is empty, or when its current result is being taken in the same cycle. If the consumer holds `out_ready` low, the result stays frozen and `in_ready` drops, so back-pressure reaches the producer with no extra cycle.

The table write port is plain control. It is ignored in any cycle where a window is offered or a result is still held, so a lookup never sees a table that is half rewritten.

Top module: `idec_decoder`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: A zero word ends the decode as undefined: `out_undef`=1, `out_id`=0, and `out_len` is the number of the stage (1 to 5) that read the zero word.
- R3: A positive word (bit 15 = 0, nonzero) ends the decode. `out_id` is the identifier table entry at index bits 14:0, `out_undef`=0, and `out_len` is the number of the stage that read it.
- R4: A negative word (bit 15 = 1) continues the decode. Its bits 14:8 give the next state, taken modulo the number of states, and the next byte is looked up at decode table address {state, byte}. The first stage uses state 0, and byte k of the window sits at bits 8k+7:8k of `in_bytes`.
- R5: If the fifth stage still reads a negative word, the result is undefined with `out_len`=5 and `out_id`=0.
- R6: A positive word whose index is not below the identifier table depth is reported as undefined with `out_id`=0.
- R7: `out_prefix` carries bits 7:0 of the last negative word met before the decode ends. It is 0 when the first stage ends the decode.
- R8: A result becomes valid in the cycle after its window is accepted. While `out_valid`=1 and `out_ready`=0, every output holds its value and `in_ready`=0. Otherwise `in_ready`=1.
- R9: A table write is applied only in a cycle where both `in_valid` and `out_valid` are 0. Otherwise it is dropped. `wr_final`=0 writes the decode table and `wr_final`=1 writes the identifier table (low bits of `wr_data`).
- R10: Window bytes beyond the stage that ends the decode have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte window offered |
| in_ready | output | 1 | Decoder can take a window |
| in_bytes | input | MAX_BYTES*8 | Byte window, first byte in bits 7:0 |
| out_valid | output | 1 | Result held |
| out_ready | input | 1 | Consumer takes the result |
| out_id | output | ID_W | Instruction identifier |
| out_len | output | LEN_W | Bytes consumed |
| out_undef | output | 1 | Undefined-opcode exception |
| out_prefix | output | 8 | Partial decode of last continuation |
| wr_en | input | 1 | Table write request |
| wr_final | input | 1 | 0: decode table, 1: identifier table |
| wr_addr | input | WA_W | Write address |
| wr_data | input | 16 | Write data |

## Verification
The bench chains continuation words through states whose state field exceeds the state count. A design that skipped the modulo step would read the wrong row and return the wrong identifier. It runs chains that are still continuing at the fifth byte and positive words that point past the identifier table. A design that let either of these through would return a defined instruction where a trap is required. It repeats a short decode with different trailing bytes, which exposes a decoder that keeps looking past the stage that ended the decode. It also attempts table writes while a result is stalled and while a window is offered. A design that let such a write through would change a later decode's identifier.

// File: rtl/idec_pkg.sv
package idec_pkg;
  localparam int ENT_W = 16;
  localparam int BYTE_W = 8;

  function automatic logic ent_cont(input logic [ENT_W-1:0] e);
    return e[ENT_W-1];
  endfunction

  function automatic logic [6:0] ent_state(input logic [ENT_W-1:0] e);
    return e[14:8];
  endfunction

  function automatic logic [7:0] ent_part(input logic [ENT_W-1:0] e);
    return e[7:0];
  endfunction

  function automatic logic [14:0] ent_index(input logic [ENT_W-1:0] e);
    return e[14:0];
  endfunction
endpackage

// File: rtl/idec_dtab.sv
module idec_dtab #(
  parameter int AW  = 11,
  parameter int NRD = 5
) (
  input  logic                             clk,
  input  logic                             we,
  input  logic [AW-1:0]                    waddr,
  input  logic [idec_pkg::ENT_W-1:0]       wdata,
  input  logic [NRD*AW-1:0]                raddr,
  output logic [NRD*idec_pkg::ENT_W-1:0]   rdata
);
  localparam int DEPTH = 1 << AW;
  localparam int EW = idec_pkg::ENT_W;

  logic [EW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rdata[g*EW +: EW] = mem[raddr[g*AW +: AW]];
  end
endmodule

// File: rtl/idec_ftab.sv
module idec_ftab #(
  parameter int DEPTH = 64,
  parameter int AW    = 6,
  parameter int W     = 12
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/idec_stage.sv
module idec_stage #(
  parameter int STATE_W = 3
) (
  input  logic                       act_i,
  input  logic [idec_pkg::ENT_W-1:0] ent,
  output logic                       act_o,
  output logic [STATE_W-1:0]         st_o,
  output logic                       hit_o
);
  import idec_pkg::*;
  logic [6:0] st_full;

  assign st_full = ent_state(ent);
  assign act_o   = act_i && ent_cont(ent);
  assign hit_o   = act_i && !ent_cont(ent);
  assign st_o    = st_full[STATE_W-1:0];
endmodule

// File: rtl/idec_decoder.sv
module idec_decoder #(
  parameter int MAX_BYTES   = 5,
  parameter int STATE_W     = 3,
  parameter int FINAL_DEPTH = 64,
  parameter int ID_W        = 12,
  localparam int DT_AW = STATE_W + 8,
  localparam int FT_AW = $clog2(FINAL_DEPTH),
  localparam int WA_W  = (DT_AW > FT_AW) ? DT_AW : FT_AW,
  localparam int LEN_W = $clog2(MAX_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [MAX_BYTES*8-1:0] in_bytes,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [ID_W-1:0]        out_id,
  output logic [LEN_W-1:0]       out_len,
  output logic                   out_undef,
  output logic [7:0]             out_prefix,
  input  logic                   wr_en,
  input  logic                   wr_final,
  input  logic [WA_W-1:0]        wr_addr,
  input  logic [15:0]            wr_data
);
  import idec_pkg::*;
  localparam int EW = ENT_W;

  logic                           busy, dt_we, ft_we, fire;
  logic [MAX_BYTES:0]             act;
  logic [(MAX_BYTES+1)*STATE_W-1:0] st;
  logic [MAX_BYTES-1:0]           hit;
  logic [MAX_BYTES*DT_AW-1:0]     raddr;
  logic [MAX_BYTES*EW-1:0]        rdata;
  logic [ID_W-1:0]                ft_rd;
  logic [LEN_W-1:0]               n_len;
  logic                           n_undef, n_zero, done;
  logic [14:0]                    n_idx;
  logic [7:0]                     n_pref;
  logic [EW-1:0]                  e;

  assign busy  = in_valid | out_valid;
  assign dt_we = wr_en & ~wr_final & ~busy;
  assign ft_we = wr_en & wr_final & ~busy;

  idec_dtab #(.AW(DT_AW), .NRD(MAX_BYTES)) u_dtab (
    .clk(clk), .we(dt_we), .waddr(wr_addr[DT_AW-1:0]), .wdata(wr_data),
    .raddr(raddr), .rdata(rdata)
  );

  assign act[0] = 1'b1;
  assign st[STATE_W-1:0] = '0;

  for (genvar k = 0; k < MAX_BYTES; k++) begin : g_stage
    assign raddr[k*DT_AW +: DT_AW] = {st[k*STATE_W +: STATE_W], in_bytes[k*8 +: 8]};
    idec_stage #(.STATE_W(STATE_W)) u_stage (
      .act_i(act[k]),
      .ent(rdata[k*EW +: EW]),
      .act_o(act[k+1]),
      .st_o(st[(k+1)*STATE_W +: STATE_W]),
      .hit_o(hit[k])
    );
  end

  // First terminating stage selects the result; continuations feed the prefix.
  always_comb begin
    done   = 1'b0;
    n_len  = LEN_W'(MAX_BYTES);
    n_idx  = '0;
    n_zero = 1'b1;
    n_pref = '0;
    for (int k = 0; k < MAX_BYTES; k++) begin
      e = rdata[k*EW +: EW];
      if (!done) begin
        if (hit[k]) begin
          done   = 1'b1;
          n_len  = LEN_W'(k + 1);
          n_idx  = ent_index(e);
          n_zero = (e == '0);
        end else begin
          n_pref = ent_part(e);
        end
      end
    end
    n_undef = !done || n_zero || (n_idx >= 15'(FINAL_DEPTH));
  end

  idec_ftab #(.DEPTH(FINAL_DEPTH), .AW(FT_AW), .W(ID_W)) u_ftab (
    .clk(clk), .we(ft_we), .waddr(wr_addr[FT_AW-1:0]), .wdata(wr_data[ID_W-1:0]),
    .raddr(n_idx[FT_AW-1:0]), .rdata(ft_rd)
  );

  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_id     <= '0;
      out_len    <= '0;
      out_undef  <= 1'b0;
      out_prefix <= '0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (fire) begin
        out_id     <= n_undef ? '0 : ft_rd;
        out_len    <= n_len;
        out_undef  <= n_undef;
        out_prefix <= n_pref;
      end
    end
  end
endmodule

// File: rtl/idec_chk.sv
module idec_chk #(
  parameter int MAX_BYTES = 5,
  parameter int ID_W      = 12,
  parameter int LEN_W     = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [ID_W-1:0]  out_id,
  input logic [LEN_W-1:0] out_len,
  input logic             out_undef,
  input logic [7:0]       out_prefix
);
  p_len_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_len >= LEN_W'(1)) && (out_len <= LEN_W'(MAX_BYTES)));

  p_undef_id_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_undef |-> out_id == '0);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_id) && $stable(out_len)
      && $stable(out_undef) && $stable(out_prefix));

  p_backpressure_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  p_short_prefix_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_len == LEN_W'(1) |-> out_prefix == 8'h00);
endmodule

bind idec_decoder idec_chk #(.MAX_BYTES(MAX_BYTES), .ID_W(ID_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_id(out_id),
  .out_len(out_len), .out_undef(out_undef), .out_prefix(out_prefix)
);

// File: tb/idec_decoder_bench.sv
module idec_decoder_bench;
  localparam int NB = 5, SW = 3, FD = 64, IW = 12;
  localparam int DTD = 2048;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic [39:0] in_bytes = '0;
  logic in_ready, out_valid, out_undef;
  logic [IW-1:0] out_id;
  logic [2:0] out_len;
  logic [7:0] out_prefix;
  logic wr_en = 1'b0, wr_final = 1'b0;
  logic [10:0] wr_addr = '0;
  logic [15:0] wr_data = '0;

  int n_run = 0, n_fail = 0;
  bit ended = 0;

  logic [15:0] m_dt [DTD];
  logic [IW-1:0] m_ft [FD];

  always #4 clk = ~clk;

  idec_decoder u_idec_decoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_bytes(in_bytes), .out_valid(out_valid), .out_ready(out_ready),
    .out_id(out_id), .out_len(out_len), .out_undef(out_undef),
    .out_prefix(out_prefix), .wr_en(wr_en), .wr_final(wr_final),
    .wr_addr(wr_addr), .wr_data(wr_data)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void ref_dec(input logic [39:0] b, output logic [IW-1:0] id,
                                  output logic [2:0] len, output logic undef,
                                  output logic [7:0] pref);
    logic [2:0] s;
    logic [15:0] e;
    bit done;
    s = 0; pref = 0; len = 3'd5; undef = 1; id = 0; done = 0;
    for (int k = 0; k < NB; k++) begin
      if (!done) begin
        e = m_dt[{s, b[8*k +: 8]}];
        if (e[15]) begin
          s = e[10:8];
          pref = e[7:0];
        end else begin
          done = 1;
          len = 3'(k + 1);
          if (e == 16'h0 || e[14:0] >= 15'(FD)) undef = 1;
          else begin undef = 0; id = m_ft[e[5:0]]; end
        end
      end
    end
  endfunction

  task automatic wr(input bit fin, input int addr, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1; wr_final = fin; wr_addr = 11'(addr); wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 0;
    if (fin) m_ft[addr] = d[IW-1:0]; else m_dt[addr] = d;
  endtask

  task automatic dec(input logic [39:0] b, input string tag);
    logic [IW-1:0] eid; logic [2:0] elen; logic eu; logic [7:0] ep;
    ref_dec(b, eid, elen, eu, ep);
    @(negedge clk);
    in_valid = 1; in_bytes = b;
    @(posedge clk);
    @(negedge clk);
    in_valid = 0;
    check({tag, " valid R8"}, 32'(out_valid), 1);
    check({tag, " id"}, 32'(out_id), 32'(eid));
    check({tag, " len"}, 32'(out_len), 32'(elen));
    check({tag, " undef"}, 32'(out_undef), 32'(eu));
    check({tag, " prefix R7"}, 32'(out_prefix), 32'(ep));
  endtask

  function automatic logic [15:0] neg(input int st, input int p);
    return {1'b1, 7'(st), 8'(p)};
  endfunction

  initial begin
    #(8 * 150000);
    if (!ended) begin
      ended = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [IW-1:0] id1; logic [2:0] l1; logic u1; logic [7:0] p1;
    void'($urandom(32'h5eed1d));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 out_valid at reset", 32'(out_valid), 0);
    check("R1 in_ready at reset", 32'(in_ready), 1);
    rst_n = 1;

    // Random table fill (R9 idle writes)
    for (int i = 0; i < FD; i++) wr(1, i, 16'($urandom));
    for (int i = 0; i < DTD; i++) begin
      int r = $urandom % 4;
      if (r == 0) wr(0, i, 16'h0);
      else if (r == 1) wr(0, i, {1'b0, 15'(1 + $urandom % (FD + 8))});
      else wr(0, i, neg($urandom % 128, $urandom % 256));
    end

    // R2: zero word at first stage
    wr(0, 11'h000, 16'h0);
    dec(40'h00, "R2 zero first");
    check("R2 len literal", 32'(out_len), 1);
    // R3: positive at first stage
    wr(1, 7, 16'h0abc);
    wr(0, 11'h010, 16'h0007);
    dec(40'hff_ee_dd_cc_10, "R3 pos first");
    check("R3 id literal", 32'(out_id), 32'h0abc);
    // R10: trailing bytes ignored
    dec(40'h12_34_56_78_10, "R10 trailing bytes");
    check("R10 id literal", 32'(out_id), 32'h0abc);
    // R4: chain with state modulo
    wr(0, {3'd0, 8'h20}, neg(3, 8'h11));
    wr(0, {3'd3, 8'h21}, neg(8'h0d, 8'h22));
    wr(1, 9, 16'h0123);
    wr(0, {3'd5, 8'h22}, 16'h0009);
    dec(40'h99_99_22_21_20, "R4 chain len3");
    check("R4 id literal", 32'(out_id), 32'h0123);
    check("R4 len literal", 32'(out_len), 3);
    check("R7 prefix literal", 32'(out_prefix), 32'h22);
    // R2 zero at later stage
    wr(0, {3'd5, 8'h23}, 16'h0);
    dec(40'h00_00_23_21_20, "R2 zero stage3");
    // R5: still continuing at fifth stage
    wr(0, {3'd0, 8'h30}, neg(1, 1));
    wr(0, {3'd1, 8'h31}, neg(2, 2));
    wr(0, {3'd2, 8'h32}, neg(4, 3));
    wr(0, {3'd4, 8'h33}, neg(6, 4));
    wr(0, {3'd6, 8'h34}, neg(7, 5));
    dec(40'h34_33_32_31_30, "R5 overlong");
    check("R5 undef literal", 32'(out_undef), 1);
    check("R5 len literal", 32'(out_len), 5);
    // R6: index beyond identifier table
    wr(0, {3'd0, 8'h40}, 16'd100);
    dec(40'h40, "R6 index range");
    check("R6 undef literal", 32'(out_undef), 1);

    // R8 / R9: back-pressure and blocked writes
    ref_dec(40'h10, id1, l1, u1, p1);
    @(negedge clk);
    out_ready = 0; in_valid = 1; in_bytes = 40'h10;
    @(posedge clk);
    @(negedge clk);
    in_valid = 0;
    check("R8 valid stalled", 32'(out_valid), 1);
    check("R8 in_ready low", 32'(in_ready), 0);
    wr_en = 1; wr_final = 0; wr_addr = 11'h010; wr_data = 16'h0003;
    @(posedge clk);
    @(negedge clk);
    wr_en = 0;
    check("R8 id held", 32'(out_id), 32'(id1));
    check("R8 valid held", 32'(out_valid), 1);
    out_ready = 1;
    @(posedge clk);
    @(negedge clk);
    check("R8 valid drops", 32'(out_valid), 0);
    check("R8 in_ready back", 32'(in_ready), 1);
    // write while a window is offered: dropped
    in_valid = 1; in_bytes = 40'h77;
    wr_en = 1; wr_final = 1; wr_addr = 11'd7; wr_data = 16'h0555;
    @(posedge clk);
    @(negedge clk);
    in_valid = 0; wr_en = 0;
    dec(40'h10, "R9 blocked writes");
    check("R9 id unchanged", 32'(out_id), 32'h0abc);
    // idle write applies
    wr(1, 7, 16'h0777);
    dec(40'h10, "R9 idle write");
    check("R9 id updated", 32'(out_id), 32'h0777);

    // Random decodes
    for (int i = 0; i < 300; i++) begin
      logic [39:0] b;
      b = {8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom)};
      if (i % 3 == 0) b[7:0] = 8'h20;
      dec(b, "R3 R4 random");
    end

    if (!ended) begin
      ended = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule